// File: doc/BRIEF.md
# Dual-Channel Serial Controller Host Front End

This block is the host-facing side of a two-channel serial controller. It watches two active-low strobes (`wr_n`, `rd_n`), a channel select and a command/data select, all sampled on the system clock. From these it steers each access to the right per-channel resource: the transmit holding byte, the indirectly addressed control registers, the receive holding byte or the status byte. Read data and interrupt vectors leave on an 8-bit tri-state bus, modelled as a data output plus an output enable. The serial engines are replaced by small stubs: loadable receive bytes, takeable transmit bytes and per-source event pulses.

Each channel keeps sticky pending-interrupt flags. The active-low open-drain request is modelled as a pull enable. A priority input and the vector settings in control register 2 of channel A gate that request. When vector mode is on, an acknowledge interval puts a vector on the bus. The vector is built from the base held in control register 2 of channel B, with its low three bits replaced by a code for the highest-ranked pending source.

Top module: `sio_host_front`

## Requirements
- R1: With `wr_n` low and `rd_n` high, `ctl_sel`=0 stores `bus_in` into the transmit byte of the channel chosen by `chan_b` (0 = A, 1 = B). The byte appears on that channel's `tx_data` output and sets status bit 1. A `tx_take` pulse clears status bit 1.
- R2: A control write made while the channel's register pointer is 0 loads the pointer from bits 2:0. If bit 3 is set, the same write clears all of that channel's pending flags. The next control write goes to the selected register, and the pointer then returns to 0. In channel A's register 2, bit 7 enables vector mode and bits 5:3 hold the vector type. Channel B's register 2 is the vector base.
- R3: With `rd_n` low and `wr_n` high, the bus is driven. `ctl_sel`=0 returns the channel's receive byte. `ctl_sel`=1 returns status: bit 0 is receive valid, bit 1 is transmit full, bits 4:2 are pending flags for sources 0..2, and the other bits are 0. Receive valid clears when a receive-byte read ends.
- R4: With both strobes high and no acknowledge interval, `bus_oe` is 0. With both strobes low, `bus_oe` is 0 and no register, buffer or flag changes.
- R5: A one-cycle pulse on an `ev_a`/`ev_b` bit sets the matching pending flag. The flag stays set until a clearing control write.
- R6: If a clearing control write and an event fall in the same cycle, the event's flag ends up set and all other flags end up cleared.
- R7: `irq_pull` is 1 exactly when some flag is pending and at least one of these holds: vector mode is off, the type is 010 or 100, or `pri_n` is 0.
- R8: In vector mode, an acknowledge interval is `ack_n` low with both strobes high. During it the bus is driven only while `pri_n` is 0. The bus carries the base's bits 7:3 and a low code: channel A sources 0..2 give 0..2, channel B sources 0..2 give 4..6, and no pending source gives 7. Channel A outranks B, and a lower source number outranks a higher one.
- R9: The vector is captured in the first cycle of an acknowledge interval and stays unchanged until the interval ends, even if new events arrive.
- R10: With vector mode off, `ack_n` has no effect and the bus stays undriven.
- R11: After reset, `bus_oe`, `irq_pull`, both `tx_data` outputs and both status bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| chan_b | input | 1 | Channel select, 0 = A, 1 = B |
| ctl_sel | input | 1 | 0 = data buffers, 1 = control/status |
| bus_in | input | 8 | Data bus as driven by the host |
| bus_out | output | 8 | Data bus value driven by the block |
| bus_oe | output | 1 | Bus output enable |
| ack_n | input | 1 | Active-low interrupt acknowledge |
| pri_n | input | 1 | Active-low priority input |
| irq_pull | output | 1 | Pull enable of the open-drain request |
| rx_load | input | 2 | Stub: load `rx_byte` into channel A (bit 0) or B (bit 1) |
| rx_byte | input | 8 | Stub received byte |
| tx_take | input | 2 | Stub: transmitter takes channel A/B byte |
| ev_a | input | 3 | Stub event pulses, channel A sources 0..2 |
| ev_b | input | 3 | Stub event pulses, channel B sources 0..2 |
| tx_data_a | output | 8 | Channel A transmit byte |
| tx_data_b | output | 8 | Channel B transmit byte |

## Verification
Two functions can land in the same clock cycle. The first is a clearing control write meeting a new source event. The bench drives the write strobe and the event pulse at the same falling edge and then reads status, which must show only the new flag. The second is an event arriving inside an acknowledge interval. The bench samples the bus in the first cycle of the interval, injects a higher-ranked event, and samples again after that event is registered. The two samples must match, and a fresh acknowledge afterwards must carry the new code.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_WR_DATA,
        ACC_WR_CTRL,
        ACC_RD_DATA,
        ACC_RD_STAT
    } acc_e;

    localparam int STAT_RXV_BIT = 0;
    localparam int STAT_TXF_BIT = 1;
    localparam int STAT_PEND_LO = 2;

endpackage

// File: rtl/sio_access_decode.sv
module sio_access_decode
    import sio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    input  logic rd_n,
    input  logic ctl_sel,
    input  logic chan_b,
    output acc_e kind_now,
    output logic wr_go,
    output logic rx_rd_done,
    output logic done_ch
);

    typedef struct packed {
        acc_e kind;
        logic ch;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        case ({wr_n, rd_n})
            2'b01:   kind_now = ctl_sel ? ACC_WR_CTRL : ACC_WR_DATA;
            2'b10:   kind_now = ctl_sel ? ACC_RD_STAT : ACC_RD_DATA;
            default: kind_now = ACC_NONE;
        endcase
        dec_d.kind = kind_now;
        dec_d.ch   = chan_b;
        wr_go      = (kind_now == ACC_WR_DATA || kind_now == ACC_WR_CTRL)
                     && (kind_now != dec_q.kind);
        rx_rd_done = (dec_q.kind == ACC_RD_DATA) && (kind_now != ACC_RD_DATA);
        done_ch    = dec_q.ch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '{kind: ACC_NONE, ch: 1'b0};
        else        dec_q <= dec_d;
    end

    assert_prohibited_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !rd_n) |-> !wr_go);

    assert_single_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> !wr_go || ($past(ctl_sel) != ctl_sel));

endmodule

// File: rtl/sio_chan.sv
module sio_chan
    import sio_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NSRC = 3,
    parameter int NREG = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_go,
    input  logic            wr_ctl,
    input  logic [DW-1:0]   wdata,
    input  logic            rx_done,
    input  logic            rx_load,
    input  logic [DW-1:0]   rx_byte,
    input  logic            tx_take,
    input  logic [NSRC-1:0] ev,
    output logic [DW-1:0]   rx_data,
    output logic [DW-1:0]   status,
    output logic [DW-1:0]   tx_data,
    output logic [NSRC-1:0] pend,
    output logic [DW-1:0]   reg2
);

    localparam int PW      = $clog2(NREG);
    localparam int CLR_BIT = PW;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic [PW-1:0]           ptr;
        logic [DW-1:0]           rx;
        logic                    rxv;
        logic [DW-1:0]           tx;
        logic                    txf;
        logic [NSRC-1:0]         pend;
    } ch_t;

    ch_t  ch_d, ch_q;
    logic clr_cmd;

    always_comb begin
        ch_d    = ch_q;
        clr_cmd = 1'b0;
        if (tx_take) ch_d.txf = 1'b0;
        if (wr_go) begin
            if (wr_ctl) begin
                if (ch_q.ptr == '0) begin
                    ch_d.ptr = wdata[PW-1:0];
                    clr_cmd  = wdata[CLR_BIT];
                end else begin
                    ch_d.regs[ch_q.ptr] = wdata;
                    ch_d.ptr            = '0;
                end
            end else begin
                ch_d.tx  = wdata;
                ch_d.txf = 1'b1;
            end
        end
        ch_d.pend = (clr_cmd ? '0 : ch_q.pend) | ev;
        if (rx_done) ch_d.rxv = 1'b0;
        if (rx_load) begin
            ch_d.rx  = rx_byte;
            ch_d.rxv = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    always_comb begin
        status                             = '0;
        status[STAT_RXV_BIT]               = ch_q.rxv;
        status[STAT_TXF_BIT]               = ch_q.txf;
        status[STAT_PEND_LO+NSRC-1:STAT_PEND_LO] = ch_q.pend;
    end

    assign rx_data = ch_q.rx;
    assign tx_data = ch_q.tx;
    assign pend    = ch_q.pend;
    assign reg2    = ch_q.regs[2];

    assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((ch_q.pend & $past(ev)) == $past(ev)));

    assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_go && wr_ctl && ch_q.ptr == '0 && wdata[CLR_BIT])
        |=> ((ch_q.pend & $past(ch_q.pend)) == $past(ch_q.pend)));

    assert_clear_keeps_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && wr_ctl && ch_q.ptr == '0 && wdata[CLR_BIT])
        |=> (ch_q.pend == $past(ev)));

    assert_rx_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_load) |=> !ch_q.rxv);

endmodule

// File: rtl/sio_irq_vec.sv
module sio_irq_vec #(
    parameter int DW   = 8,
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   mode,
    input  logic [DW-1:0]   base,
    input  logic [NSRC-1:0] pend_a,
    input  logic [NSRC-1:0] pend_b,
    input  logic            pri_n,
    input  logic            ack_n,
    input  logic            wr_n,
    input  logic            rd_n,
    output logic            irq_pull,
    output logic            vec_oe,
    output logic [DW-1:0]   vec_out
);

    localparam int IW     = $clog2(NSRC);
    localparam int CW     = IW + 1;
    localparam int VM_BIT = 7;
    localparam int TY_LO  = 3;

    typedef struct packed {
        logic          in_ack;
        logic [DW-1:0] vec;
    } iv_t;

    iv_t           iv_d, iv_q;
    logic [CW-1:0] code;
    logic [DW-1:0] vec_now;
    logic [2:0]    vtype;
    logic          vmode, ack_now, free_type;

    always_comb begin
        code = '1;
        for (int i = NSRC - 1; i >= 0; i--)
            if (pend_b[i]) code = {1'b1, IW'(i)};
        for (int i = NSRC - 1; i >= 0; i--)
            if (pend_a[i]) code = {1'b0, IW'(i)};
    end

    always_comb begin
        vmode     = mode[VM_BIT];
        vtype     = mode[TY_LO+2:TY_LO];
        free_type = (vtype == 3'b010) || (vtype == 3'b100);
        irq_pull  = ((|pend_a) || (|pend_b)) && (!vmode || free_type || !pri_n);
        ack_now   = vmode && !ack_n && rd_n && wr_n;
        vec_now   = {base[DW-1:CW], code};
        iv_d.in_ack = ack_now;
        iv_d.vec    = (ack_now && !iv_q.in_ack) ? vec_now : iv_q.vec;
        vec_out     = iv_q.in_ack ? iv_q.vec : vec_now;
        vec_oe      = ack_now && !pri_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) iv_q <= '0;
        else        iv_q <= iv_d;
    end

    assert_vec_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_now |=> (!ack_now || vec_out == $past(vec_out)));

    assert_no_irq_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_a == '0 && pend_b == '0) |-> !irq_pull);

endmodule

// File: rtl/sio_host_front.sv
module sio_host_front
    import sio_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NSRC = 3,
    parameter int NREG = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_n,
    input  logic            rd_n,
    input  logic            chan_b,
    input  logic            ctl_sel,
    input  logic [DW-1:0]   bus_in,
    output logic [DW-1:0]   bus_out,
    output logic            bus_oe,
    input  logic            ack_n,
    input  logic            pri_n,
    output logic            irq_pull,
    input  logic [1:0]      rx_load,
    input  logic [DW-1:0]   rx_byte,
    input  logic [1:0]      tx_take,
    input  logic [NSRC-1:0] ev_a,
    input  logic [NSRC-1:0] ev_b,
    output logic [DW-1:0]   tx_data_a,
    output logic [DW-1:0]   tx_data_b
);

    localparam int NCH = 2;

    acc_e            kind_now;
    logic            wr_go, rx_rd_done, done_ch, read_on, vec_oe;
    logic [DW-1:0]   vec_out;
    logic [NSRC-1:0] ev_arr   [NCH];
    logic [NSRC-1:0] pend_arr [NCH];
    logic [DW-1:0]   rx_arr   [NCH];
    logic [DW-1:0]   stat_arr [NCH];
    logic [DW-1:0]   tx_arr   [NCH];
    logic [DW-1:0]   reg2_arr [NCH];

    assign ev_arr[0] = ev_a;
    assign ev_arr[1] = ev_b;

    sio_access_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_n       (wr_n),
        .rd_n       (rd_n),
        .ctl_sel    (ctl_sel),
        .chan_b     (chan_b),
        .kind_now   (kind_now),
        .wr_go      (wr_go),
        .rx_rd_done (rx_rd_done),
        .done_ch    (done_ch)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sio_chan #(.DW(DW), .NSRC(NSRC), .NREG(NREG)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_go   (wr_go && (chan_b == 1'(c))),
            .wr_ctl  (kind_now == ACC_WR_CTRL),
            .wdata   (bus_in),
            .rx_done (rx_rd_done && (done_ch == 1'(c))),
            .rx_load (rx_load[c]),
            .rx_byte (rx_byte),
            .tx_take (tx_take[c]),
            .ev      (ev_arr[c]),
            .rx_data (rx_arr[c]),
            .status  (stat_arr[c]),
            .tx_data (tx_arr[c]),
            .pend    (pend_arr[c]),
            .reg2    (reg2_arr[c])
        );
    end

    sio_irq_vec #(.DW(DW), .NSRC(NSRC)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (reg2_arr[0]),
        .base     (reg2_arr[1]),
        .pend_a   (pend_arr[0]),
        .pend_b   (pend_arr[1]),
        .pri_n    (pri_n),
        .ack_n    (ack_n),
        .wr_n     (wr_n),
        .rd_n     (rd_n),
        .irq_pull (irq_pull),
        .vec_oe   (vec_oe),
        .vec_out  (vec_out)
    );

    always_comb begin
        read_on = (kind_now == ACC_RD_DATA) || (kind_now == ACC_RD_STAT);
        bus_oe  = read_on || vec_oe;
        if (read_on) bus_out = ctl_sel ? stat_arr[chan_b] : rx_arr[chan_b];
        else         bus_out = vec_out;
    end

    assign tx_data_a = tx_arr[0];
    assign tx_data_b = tx_arr[1];

    assert_hiz_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n && rd_n && ack_n) |-> !bus_oe);

    assert_both_low_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !rd_n) |-> !bus_oe);

    assert_pri_blocks_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_n && rd_n) |-> !bus_oe);

    assert_nonvec_ignores_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg2_arr[0][7] && rd_n) |-> !bus_oe);

    assert_read_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && wr_n) |-> bus_oe);

endmodule

// File: tb/tb_sio_host_front.sv
`timescale 1ns/1ps
module tb_sio_host_front;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1, rd_n = 1'b1, chan_b = 1'b0, ctl_sel = 1'b0;
    logic [7:0] bus_in = '0, rx_byte = '0;
    logic       ack_n = 1'b1, pri_n = 1'b1;
    logic [1:0] rx_load = '0, tx_take = '0;
    logic [2:0] ev_a = '0, ev_b = '0;
    logic [7:0] bus_out, tx_data_a, tx_data_b;
    logic       bus_oe, irq_pull;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    sio_host_front dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .chan_b(chan_b),
        .ctl_sel(ctl_sel), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .ack_n(ack_n), .pri_n(pri_n), .irq_pull(irq_pull), .rx_load(rx_load),
        .rx_byte(rx_byte), .tx_take(tx_take), .ev_a(ev_a), .ev_b(ev_b),
        .tx_data_a(tx_data_a), .tx_data_b(tx_data_b)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic ch, input logic cd, input logic [7:0] d);
        @(negedge clk); chan_b = ch; ctl_sel = cd; bus_in = d; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_read(input logic ch, input logic cd,
                             output logic [7:0] val, output logic oe);
        @(negedge clk); chan_b = ch; ctl_sel = cd; rd_n = 1'b0;
        #1; val = bus_out; oe = bus_oe;
        @(negedge clk); rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_reg2(input logic ch, input logic [7:0] v);
        host_write(ch, 1'b1, 8'h02);
        host_write(ch, 1'b1, v);
    endtask

    task automatic clear_both;
        host_write(1'b0, 1'b1, 8'h08);
        host_write(1'b1, 1'b1, 8'h08);
    endtask

    task automatic pulse_ev(input logic [2:0] a, input logic [2:0] b);
        @(negedge clk); ev_a = a; ev_b = b;
        @(negedge clk); ev_a = '0; ev_b = '0;
    endtask

    task automatic do_ack(output logic [7:0] val, output logic oe);
        @(negedge clk); ack_n = 1'b0;
        #1; val = bus_out; oe = bus_oe;
        @(negedge clk); ack_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [2:0] exp_code(input logic [5:0] p);
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 3; i++)
                if (p[c*3+i]) return 3'(c*4 + i);
        return 3'd7;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=0x0 expected=0x1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v2;
        logic oe, oe2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check(bus_oe == 1'b0, "R11 bus_oe", bus_oe, 0);
        check(irq_pull == 1'b0, "R11 irq_pull", irq_pull, 0);
        check(tx_data_a == 8'h00 && tx_data_b == 8'h00, "R11 tx_data", {tx_data_b, tx_data_a}, 0);
        host_read(1'b0, 1'b1, v, oe);
        check(v == 8'h00, "R11 status A", v, 0);
        host_read(1'b1, 1'b1, v, oe);
        check(v == 8'h00, "R11 status B", v, 0);

        // R1 transmit writes, both channels
        for (int k = 0; k < 16; k++) begin
            host_write(1'b0, 1'b0, 8'(k * 17));
            check(tx_data_a == 8'(k * 17), "R1 tx A", tx_data_a, k * 17);
            host_write(1'b1, 1'b0, 8'(255 - k * 13));
            check(tx_data_b == 8'(255 - k * 13), "R1 tx B", tx_data_b, 255 - k * 13);
            check(tx_data_a == 8'(k * 17), "R1 tx A kept", tx_data_a, k * 17);
        end
        host_read(1'b0, 1'b1, v, oe);
        check(v == 8'h02, "R1 txf set", v, 2);
        @(negedge clk); tx_take = 2'b01; @(negedge clk); tx_take = 2'b00;
        host_read(1'b0, 1'b1, v, oe);
        check(v == 8'h00, "R1 txf cleared", v, 0);
        host_read(1'b1, 1'b1, v, oe);
        check(v == 8'h02, "R1 B txf untouched", v, 2);
        @(negedge clk); tx_take = 2'b10; @(negedge clk); tx_take = 2'b00;

        // R3 receive reads
        for (int k = 0; k < 8; k++) begin
            logic ch;
            ch = 1'(k & 1);
            @(negedge clk); rx_byte = 8'(k * 29 + 3); rx_load = ch ? 2'b10 : 2'b01;
            @(negedge clk); rx_load = 2'b00;
            host_read(ch, 1'b1, v, oe);
            check(v == 8'h01 && oe, "R3 rxv status", v, 1);
            host_read(ch, 1'b0, v, oe);
            check(v == 8'(k * 29 + 3) && oe, "R3 rx data", v, k * 29 + 3);
            host_read(ch, 1'b1, v, oe);
            check(v == 8'h00, "R3 rxv cleared", v, 0);
        end

        // R4 idle bus
        @(negedge clk); #1;
        check(bus_oe == 1'b0, "R4 idle hiz", bus_oe, 0);

        // R5 sticky events and R2 clear command
        pulse_ev(3'b101, 3'b000);
        repeat (4) @(negedge clk);
        host_read(1'b0, 1'b1, v, oe);
        check(v == 8'h14, "R5 pend A sticky", v, 8'h14);
        host_read(1'b1, 1'b1, v, oe);
        check(v == 8'h00, "R5 pend B clean", v, 0);
        host_write(1'b1, 1'b1, 8'h08);
        host_read(1'b0, 1'b1, v, oe);
        check(v == 8'h14, "R2 clear B leaves A", v, 8'h14);
        host_write(1'b0, 1'b1, 8'h08);
        host_read(1'b0, 1'b1, v, oe);
        check(v == 8'h00, "R2 clear A", v, 0);

        // R6 clear and event in the same cycle
        pulse_ev(3'b001, 3'b000);
        @(negedge clk); chan_b = 1'b0; ctl_sel = 1'b1; bus_in = 8'h08; wr_n = 1'b0; ev_a = 3'b010;
        @(negedge clk); wr_n = 1'b1; ev_a = '0;
        @(negedge clk);
        host_read(1'b0, 1'b1, v, oe);
        check(v == 8'h08, "R6 event wins over clear", v, 8'h08);
        clear_both();

        // R7 request gating sweep
        pulse_ev(3'b001, 3'b000);
        for (int vm = 0; vm < 2; vm++)
            for (int ty = 0; ty < 8; ty++) begin
                set_reg2(1'b0, 8'((vm << 7) | (ty << 3)));
                for (int p = 0; p < 2; p++) begin
                    bit e;
                    @(negedge clk); pri_n = 1'(p); #1;
                    e = (vm == 0) || (ty == 2) || (ty == 4) || (p == 0);
                    check(irq_pull == e, "R7 irq gating", irq_pull, e);
                end
            end
        clear_both();
        @(negedge clk); pri_n = 1'b0; #1;
        check(irq_pull == 1'b0, "R7 no pending", irq_pull, 0);

        // R8 vector sweep over all pending patterns
        set_reg2(1'b0, 8'h80);
        for (int p = 0; p < 64; p++) begin
            logic [7:0] base, ex;
            base = 8'(p * 37 + 5);
            set_reg2(1'b1, base);
            pulse_ev(3'(p), 3'(p >> 3));
            ex = {base[7:3], exp_code(6'(p))};
            pri_n = 1'b0;
            do_ack(v, oe);
            check(oe && v == ex, "R8 vector", {oe, v}, {1'b1, ex});
            pri_n = 1'b1;
            do_ack(v, oe);
            check(!oe, "R8 pri blocks vector", oe, 0);
            clear_both();
        end

        // R9 vector held through interval
        set_reg2(1'b1, 8'hA0);
        pulse_ev(3'b100, 3'b000);
        pri_n = 1'b0;
        @(negedge clk); ack_n = 1'b0; #1; v = bus_out;
        @(negedge clk); ev_a = 3'b001;
        @(negedge clk); ev_a = 3'b000; #1; v2 = bus_out; oe2 = bus_oe;
        check(v == 8'hA2 && v2 == 8'hA2 && oe2, "R9 vector stable", v2, 8'hA2);
        @(negedge clk); pri_n = 1'b1; #1;
        check(!bus_oe, "R8 pri high mid interval", bus_oe, 0);
        @(negedge clk); ack_n = 1'b1; pri_n = 1'b0;
        @(negedge clk);
        do_ack(v, oe);
        check(oe && v == 8'hA0, "R9 new interval new code", v, 8'hA0);
        clear_both();

        // R10 non-vector mode ignores acknowledge
        set_reg2(1'b0, 8'h10);
        pulse_ev(3'b000, 3'b010);
        pri_n = 1'b0;
        do_ack(v, oe);
        check(!oe, "R10 ack ignored", oe, 0);
        check(irq_pull, "R10 irq still raised", irq_pull, 1);
        clear_both();

        // R4 both strobes low: no access
        @(negedge clk); rx_byte = 8'h3C; rx_load = 2'b01;
        @(negedge clk); rx_load = 2'b00;
        host_write(1'b0, 1'b0, 8'h77);
        @(negedge clk); tx_take = 2'b01; @(negedge clk); tx_take = 2'b00;
        @(negedge clk); chan_b = 1'b0; ctl_sel = 1'b0; bus_in = 8'h5A; wr_n = 1'b0; rd_n = 1'b0;
        #1; oe = bus_oe;
        @(negedge clk); ctl_sel = 1'b1; bus_in = 8'h0A;
        @(negedge clk); wr_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        check(!oe, "R4 both low hiz", oe, 0);
        check(tx_data_a == 8'h77, "R4 tx untouched", tx_data_a, 8'h77);
        host_read(1'b0, 1'b1, v, oe);
        check(v == 8'h01, "R4 flags untouched", v, 1);
        host_write(1'b0, 1'b1, 8'h02);
        host_write(1'b0, 1'b1, 8'h80);
        pulse_ev(3'b001, 3'b000);
        pri_n = 1'b0;
        do_ack(v, oe);
        check(oe, "R4 pointer untouched", oe, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule